// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block keeps the instruction address of a small controller whose program and data memories are separate. The address is 13 bits wide. Software can only see its low byte. The upper five bits are never written directly. They are supplied by a separate paging latch that software loads ahead of time.

The counter changes in one of four ways. A plain step adds one. A computed write to the low byte replaces the whole address: the new byte goes to the low bits and the five latch bits go to the upper bits. A jump or call carries an 11-bit target, and its two upper bits come from latch bits 4 and 3. A return takes the address back from an eight-entry stack.

Writing the latch has no effect on the counter until a later low-byte write or jump uses it. The stack is circular with a 3-bit pointer. It never reports overflow or underflow.

Top module: `pc_page_unit`

## Requirements
- R1: While rst_ni is low, pc_o, lo_rdata_o and lat_rdata_o all read 0, and the stack pointer returns to its first slot.
- R2: With only inc_i asserted, pc_o becomes the old value plus one on the next edge, and 1FFFh wraps to 0000h.
- R3: lo_we_i (without pop_i) loads pc_o[7:0] with lo_wdata_i and pc_o[12:8] with latch bits 4:0 on the next edge.
- R4: jmp_i (without lo_we_i or pop_i) loads pc_o[10:0] with jmp_tgt_i and pc_o[12:11] with latch bits 4:3 on the next edge.
- R5: A latch write alone leaves pc_o unchanged.
- R6: lat_we_i stores lat_wdata_i[4:0]. lat_rdata_o returns those five bits in positions 4:0, and bits 7:5 always read 0.
- R7: lo_rdata_o always equals pc_o[7:0].
- R8: push_i saves the pre-edge pc_o on the stack. pop_i loads pc_o with the most recently saved value that has not yet been popped (last in, first out).
- R9: The stack holds eight entries. A ninth push overwrites the oldest entry, and a pop on an empty stack wraps round to the slot behind the pointer, with no flag raised.
- R10: When several strobes coincide, the priority for the counter is pop_i, then lo_we_i, then jmp_i, then inc_i. A push_i in the same cycle as pop_i is dropped.
- R11: A low-byte write or jump in the same cycle as a latch write uses the latch value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Step the counter by one |
| lo_we_i | input | 1 | Computed write of the low byte |
| lo_wdata_i | input | 8 | Low byte value |
| lat_we_i | input | 1 | Paging latch write enable |
| lat_wdata_i | input | 8 | Paging latch write data |
| jmp_i | input | 1 | Jump or call strobe |
| jmp_tgt_i | input | 11 | Jump target, counter bits 10:0 |
| push_i | input | 1 | Save current counter on stack |
| pop_i | input | 1 | Restore counter from stack |
| pc_o | output | 13 | Full program counter |
| lo_rdata_o | output | 8 | Low byte readback |
| lat_rdata_o | output | 8 | Paging latch readback |

## Verification
The main collision tested is a latch write that lands in the same cycle as a low-byte write or a jump. In that case the counter must take its upper bits from the old latch value, while the readback already shows the new one. The bench sets up the latch with one value, then issues both strobes together with a different latch value. It then checks pc_o against the old page bits and lat_rdata_o against the new ones. The bench also applies combinations of pop, low-byte write, jump and increment in the same cycle, and checks the outcome against the stated priority.

// File: rtl/pc_page_pkg.sv
package pc_page_pkg;
  localparam int unsigned PC_W      = 13;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned TGT_W     = 11;
  localparam int unsigned STK_DEPTH = 8;

  typedef enum logic [1:0] {
    SRC_HOLD,
    SRC_STACK,
    SRC_LOAD,
    SRC_STEP
  } pc_src_e;
endpackage

// File: rtl/pc_page_latch.sv
module pc_page_latch #(
  parameter int unsigned PAGE_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_q <= '0;
    else if (we_i) page_q <= wdata_i[PAGE_W-1:0];
  end

  assign page_o  = page_q;
  assign rdata_o = {{(DATA_W-PAGE_W){1'b0}}, page_q};
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int unsigned WIDTH = 13,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] top_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_dec;
  logic [WIDTH-1:0] slot_q [DEPTH];
  logic             do_push;

  assign do_push = push_i && !pop_i;   // pop wins on collision
  assign ptr_dec = (ptr_q == '0) ? PTR_W'(DEPTH-1) : ptr_q - 1'b1;
  assign top_o   = slot_q[ptr_dec];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (pop_i) begin
      ptr_q <= ptr_dec;
    end else if (do_push) begin
      ptr_q <= (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            slot_q[g] <= '0;
      else if (do_push && ptr_q == PTR_W'(g)) slot_q[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/pc_core.sv
module pc_core
  import pc_page_pkg::*;
#(
  parameter int unsigned PC_BITS  = 13,
  parameter int unsigned LO_BITS  = 8,
  parameter int unsigned TGT_BITS = 11,
  localparam int unsigned HI_W    = PC_BITS - LO_BITS,
  localparam int unsigned JHI_W   = PC_BITS - TGT_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                inc_i,
  input  logic                lo_we_i,
  input  logic [LO_BITS-1:0]  lo_wdata_i,
  input  logic                jmp_i,
  input  logic [TGT_BITS-1:0] jmp_tgt_i,
  input  logic                pop_i,
  input  logic [PC_BITS-1:0]  stk_top_i,
  input  logic [HI_W-1:0]     page_i,
  output logic [PC_BITS-1:0]  pc_o
);
  logic [PC_BITS-1:0] pc_q, load_val;
  pc_src_e            src;

  always_comb begin
    load_val = '0;
    if (pop_i)        src = SRC_STACK;
    else if (lo_we_i) src = SRC_LOAD;
    else if (jmp_i)   src = SRC_LOAD;
    else if (inc_i)   src = SRC_STEP;
    else              src = SRC_HOLD;
    if (lo_we_i) load_val = {page_i, lo_wdata_i};
    else         load_val = {page_i[HI_W-1 -: JHI_W], jmp_tgt_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else begin
      unique case (src)
        SRC_STACK: pc_q <= stk_top_i;
        SRC_LOAD:  pc_q <= load_val;
        SRC_STEP:  pc_q <= pc_q + 1'b1;
        default:   pc_q <= pc_q;
      endcase
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pc_page_unit.sv
module pc_page_unit
  import pc_page_pkg::*;
#(
  parameter int unsigned PC_BITS  = PC_W,
  parameter int unsigned LO_BITS  = BYTE_W,
  parameter int unsigned TGT_BITS = TGT_W,
  parameter int unsigned DEPTH    = STK_DEPTH
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                inc_i,
  input  logic                lo_we_i,
  input  logic [LO_BITS-1:0]  lo_wdata_i,
  input  logic                lat_we_i,
  input  logic [LO_BITS-1:0]  lat_wdata_i,
  input  logic                jmp_i,
  input  logic [TGT_BITS-1:0] jmp_tgt_i,
  input  logic                push_i,
  input  logic                pop_i,
  output logic [PC_BITS-1:0]  pc_o,
  output logic [LO_BITS-1:0]  lo_rdata_o,
  output logic [LO_BITS-1:0]  lat_rdata_o
);
  localparam int unsigned HI_W = PC_BITS - LO_BITS;

  logic [HI_W-1:0]    page;
  logic [PC_BITS-1:0] stk_top;

  pc_page_latch #(.PAGE_W(HI_W), .DATA_W(LO_BITS)) i_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (lat_we_i),
    .wdata_i (lat_wdata_i),
    .page_o  (page),
    .rdata_o (lat_rdata_o)
  );

  pc_ret_stack #(.WIDTH(PC_BITS), .DEPTH(DEPTH)) i_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .wdata_i (pc_o),
    .top_o   (stk_top)
  );

  pc_core #(.PC_BITS(PC_BITS), .LO_BITS(LO_BITS), .TGT_BITS(TGT_BITS)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc_i),
    .lo_we_i    (lo_we_i),
    .lo_wdata_i (lo_wdata_i),
    .jmp_i      (jmp_i),
    .jmp_tgt_i  (jmp_tgt_i),
    .pop_i      (pop_i),
    .stk_top_i  (stk_top),
    .page_i     (page),
    .pc_o       (pc_o)
  );

  assign lo_rdata_o = pc_o[LO_BITS-1:0];
endmodule

// File: rtl/pc_page_sva.sv
module pc_page_sva #(
  parameter int unsigned PC_BITS  = 13,
  parameter int unsigned LO_BITS  = 8,
  parameter int unsigned TGT_BITS = 11,
  parameter int unsigned DEPTH    = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                inc_i,
  input logic                lo_we_i,
  input logic [LO_BITS-1:0]  lo_wdata_i,
  input logic                lat_we_i,
  input logic [LO_BITS-1:0]  lat_wdata_i,
  input logic                jmp_i,
  input logic [TGT_BITS-1:0] jmp_tgt_i,
  input logic                push_i,
  input logic                pop_i,
  input logic [PC_BITS-1:0]  pc_o,
  input logic [LO_BITS-1:0]  lo_rdata_o,
  input logic [LO_BITS-1:0]  lat_rdata_o
);
  localparam int unsigned HI_W  = PC_BITS - LO_BITS;
  localparam int unsigned JHI_W = PC_BITS - TGT_BITS;

  a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !pop_i && !lo_we_i && !jmp_i) |=> pc_o == PC_BITS'($past(pc_o) + 1'b1));

  a_r3_lo_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_we_i && !pop_i) |=>
      pc_o == {$past(lat_rdata_o[HI_W-1:0]), $past(lo_wdata_i)});

  a_r4_jump_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp_i && !lo_we_i && !pop_i) |=>
      pc_o == {$past(lat_rdata_o[HI_W-1 -: JHI_W]), $past(jmp_tgt_i)});

  a_r5_latch_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !lo_we_i && !jmp_i && !pop_i) |=> $stable(pc_o));

  a_r6_latch_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_we_i |=> lat_rdata_o[HI_W-1:0] == $past(lat_wdata_i[HI_W-1:0]));
endmodule

bind pc_page_unit pc_page_sva #(
  .PC_BITS(PC_BITS), .LO_BITS(LO_BITS), .TGT_BITS(TGT_BITS), .DEPTH(DEPTH)
) i_sva (.*);

// File: tb/test_pc_page_unit.sv
module test_pc_page_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc, lo_we, lat_we, jmp, push, pop;
  logic [7:0]  lo_d, lat_d, lo_r, lat_r;
  logic [10:0] tgt;
  logic [12:0] pc;

  int checks = 0;
  int errors = 0;

  logic [12:0] m_pc;
  logic [7:0]  m_lat;
  logic [12:0] m_stk [8];
  logic [2:0]  m_ptr;

  always #10 clk = ~clk;

  pc_page_unit i_pc_page_unit (
    .clk_i(clk), .rst_ni(rst_n), .inc_i(inc), .lo_we_i(lo_we), .lo_wdata_i(lo_d),
    .lat_we_i(lat_we), .lat_wdata_i(lat_d), .jmp_i(jmp), .jmp_tgt_i(tgt),
    .push_i(push), .pop_i(pop), .pc_o(pc), .lo_rdata_o(lo_r), .lat_rdata_o(lat_r)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    inc = 0; lo_we = 0; lat_we = 0; jmp = 0; push = 0; pop = 0;
    lo_d = '0; lat_d = '0; tgt = '0;
  endtask

  // One clock with the given strobes; model next state from the requirements.
  task automatic cyc(input bit s_inc, input bit s_lo, input logic [7:0] d_lo,
                     input bit s_lat, input logic [7:0] d_lat,
                     input bit s_jmp, input logic [10:0] d_tgt,
                     input bit s_push, input bit s_pop, input string req);
    logic [12:0] npc;
    inc = s_inc; lo_we = s_lo; lo_d = d_lo; lat_we = s_lat; lat_d = d_lat;
    jmp = s_jmp; tgt = d_tgt; push = s_push; pop = s_pop;
    npc = m_pc;
    if (s_pop) begin
      m_ptr = m_ptr - 3'd1;
      npc = m_stk[m_ptr];
    end else begin
      if (s_push) begin m_stk[m_ptr] = m_pc; m_ptr = m_ptr + 3'd1; end
      if (s_lo)       npc = {m_lat[4:0], d_lo};
      else if (s_jmp) npc = {m_lat[4:3], d_tgt};
      else if (s_inc) npc = m_pc + 13'd1;
    end
    if (s_lat) m_lat = {3'b000, d_lat[4:0]};
    m_pc = npc;
    @(posedge clk); #2;
    idle();
    chk(req, 32'(pc), 32'(m_pc));
    chk("R7", 32'(lo_r), 32'(m_pc[7:0]));
    chk("R6", 32'(lat_r), 32'(m_lat));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    idle();
    m_pc = '0; m_lat = '0; m_ptr = '0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    #35;
    chk("R1", 32'(pc), 0); chk("R1", 32'(lo_r), 0); chk("R1", 32'(lat_r), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;

    // R5 / R6: latch writes alone leave the counter; upper readback bits zero
    cyc(0,0,0, 1,8'h1F, 0,0, 0,0, "R5");
    cyc(0,0,0, 1,8'hFF, 0,0, 0,0, "R5");
    chk("R6", 32'(lat_r), 32'h1F);

    // R11: latch write collides with a low-byte write and with a jump
    cyc(0,1,8'h44, 1,8'h03, 0,0, 0,0, "R11");
    chk("R11", 32'(pc), 32'h1F44);
    cyc(0,0,0, 1,8'h18, 1,11'h123, 0,0, "R11");
    chk("R11", 32'(pc), 32'h0123);

    // R3: every page value with a few low bytes
    for (int l = 0; l < 32; l++) begin
      cyc(0,0,0, 1,8'(l | 8'hE0), 0,0, 0,0, "R5");
      for (int k = 0; k < 4; k++)
        cyc(0,1,8'(l*37 + k*85 + 5), 0,0, 0,0, 0,0, "R3");
    end

    // R2: step and wrap
    cyc(0,0,0, 1,8'h1F, 0,0, 0,0, "R5");
    cyc(0,1,8'hFE, 0,0, 0,0, 0,0, "R3");
    cyc(1,0,0, 0,0, 0,0, 0,0, "R2");
    chk("R2", 32'(pc), 32'h1FFF);
    cyc(1,0,0, 0,0, 0,0, 0,0, "R2");
    chk("R2", 32'(pc), 32'h0000);
    for (int i = 0; i < 300; i++) cyc(1,0,0, 0,0, 0,0, 0,0, "R2");

    // R4: page bits 4:3 combined with many targets
    for (int l = 0; l < 32; l++) begin
      cyc(0,0,0, 1,8'(l), 0,0, 0,0, "R5");
      for (int k = 0; k < 4; k++)
        cyc(0,0,0, 0,0, 1,11'(l*61 + k*511 + 3), 0,0, "R4");
    end

    // R10: priority on the counter
    cyc(0,0,0, 1,8'h0A, 0,0, 0,0, "R5");
    cyc(1,1,8'h77, 0,0, 1,11'h555, 0,0, "R10");
    chk("R10", 32'(pc), 32'h0A77);
    cyc(1,0,0, 0,0, 1,11'h2AA, 0,0, "R10");
    chk("R10", 32'(pc), 32'h0AAA);

    // R8: call = push + jump, then returns in reverse order
    cyc(0,0,0, 0,0, 1,11'h100, 1,0, "R8");
    cyc(0,0,0, 0,0, 1,11'h200, 1,0, "R8");
    cyc(0,0,0, 0,0, 1,11'h300, 1,0, "R8");
    cyc(0,0,0, 0,0, 0,0, 0,1, "R8");
    chk("R8", 32'(pc), 32'h0A00);
    cyc(0,0,0, 0,0, 0,0, 0,1, "R8");
    chk("R8", 32'(pc), 32'h0900);
    cyc(0,0,0, 0,0, 0,0, 0,1, "R8");
    chk("R8", 32'(pc), 32'h0AAA);

    // R10: pop beats push and low write in the same cycle
    cyc(0,0,0, 0,0, 1,11'h444, 1,0, "R8");
    cyc(0,1,8'h12, 0,0, 0,0, 1,1, "R10");
    chk("R10", 32'(pc), 32'h0AAA);

    // R9: nine pushes, then ten pops (overwrite and wrap)
    for (int i = 0; i < 9; i++) begin
      cyc(0,0,0, 0,0, 1,11'(i*100 + 7), 1,0, "R9");
    end
    for (int i = 0; i < 10; i++) cyc(0,0,0, 0,0, 0,0, 0,1, "R9");
    for (int i = 0; i < 6; i++) cyc(0,0,0, 0,0, 0,0, 0,1, "R9");

    // R1: reset mid-run clears counter and latch
    @(negedge clk); rst_n = 1'b0; #3;
    chk("R1", 32'(pc), 0); chk("R1", 32'(lat_r), 0);
    @(negedge clk); rst_n = 1'b1;
    m_pc = '0; m_lat = '0; m_ptr = '0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    @(posedge clk); #2;
    cyc(0,0,0, 0,0, 0,0, 0,1, "R1");
    chk("R1", 32'(pc), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule